// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a registered 32-bit arithmetic stage that keeps results inside a representable range instead of letting them wrap. An opcode selects one of nine operations: signed or unsigned add and subtract with clamping, an add that reports signed overflow but returns the wrapped sum, and saturation of a value to a programmable bit width, applied either to the whole word or to its two 16-bit halves independently.

Every clamping event sets a sticky saturation flag. The flag stays set across later operations that do not saturate, and it falls only through reset or the clear input. The result and the flag are registered, so both appear one clock edge after the operands and the opcode are presented. The idle opcode leaves the result register untouched, so software can clear the flag without disturbing the last result.

Top module: `sat_alu`

## Requirements
- R1: While the active-low reset `rst_n` is low, `result` is 0 and `sat_flag` is 0.
- R2: Opcode 1 (signed add) returns the two's complement sum. If the true sum exceeds 0x7FFFFFFF the result is 0x7FFFFFFF, and if it is below -2^31 the result is 0x80000000. Either case is a saturation event.
- R3: Opcode 2 (signed subtract, `opnd_a` minus `opnd_b`) clamps in the same way as R2 and reports a saturation event when it clamps.
- R4: Opcode 3 (unsigned add) returns 0xFFFFFFFF and reports a saturation event when the 33-bit sum exceeds 0xFFFFFFFF. Otherwise it returns the sum.
- R5: Opcode 4 (unsigned subtract) returns 0 and reports a saturation event when `opnd_b` is greater than `opnd_a`. Otherwise it returns the difference.
- R6: Opcode 5 (flag-only add) always returns the 32-bit wrapped sum. It reports a saturation event exactly when the signed sum overflows.
- R7: Opcode 6 (signed word saturate, width n = `sat_width`) treats `opnd_a` as signed. A value above 2^n-1 gives 2^n-1, a value below -2^n gives -2^n, and either case is an event. Any other value passes through unchanged.
- R8: Opcode 7 (unsigned word saturate) treats `opnd_a` as signed. A negative value gives 0, a value above 2^n-1 gives 2^n-1, and either case is an event.
- R9: Opcodes 8 and 9 apply the rule of R7 (8) or R8 (9) to bits [15:0] and to bits [31:16] of `opnd_a` separately. Each half is sign-extended first. The low 16 bits of each lane result are packed back into the same half. An event in either lane, or in both, sets the flag once.
- R10: `sat_flag` becomes 1 on the edge after any saturation event. Operations that do not saturate never clear it.
- R11: `flag_clr` high clears `sat_flag` on the next edge. If a saturation event occurs in the same cycle, the flag is 1 after that edge.
- R12: Opcode 0 and opcodes 10 to 15 leave `result` unchanged, and they cause no saturation event.
- R13: `opnd_b` has no effect on opcodes 6 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation select (see requirements) |
| opnd_a | input | 32 | First operand; value to saturate for opcodes 6-9 |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Saturation width n for opcodes 6-9 |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest cases are the clamp boundaries and the dual-lane operations where only one half saturates. Uniformly random operands almost never land within a few counts of 0x7FFFFFFF, 0x80000000 or 2^n. The stimulus therefore draws operands from clusters around those edges, with small random offsets, and mixes in halfword patterns whose upper and lower lanes are chosen separately. Clear requests are raised at random, so they sometimes coincide with a saturating operation and sometimes with an idle opcode. This exercises the ordering of clear against set and the rule that idle opcodes hold the result.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    typedef enum logic [3:0] {
        SOP_IDLE  = 4'd0,
        SOP_SADD  = 4'd1,
        SOP_SSUB  = 4'd2,
        SOP_UADD  = 4'd3,
        SOP_USUB  = 4'd4,
        SOP_ADDF  = 4'd5,
        SOP_SSATW = 4'd6,
        SOP_USATW = 4'd7,
        SOP_SSATH = 4'd8,
        SOP_USATH = 4'd9
    } sat_op_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/sat_addsub.sv
// Add/subtract core: produces clamped signed and unsigned sums and
// differences, plus the overflow indications used for the sticky flag.
module sat_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sadd_res,
    output logic         sadd_ovf,
    output logic [W-1:0] ssub_res,
    output logic         ssub_ovf,
    output logic [W-1:0] uadd_res,
    output logic         uadd_ovf,
    output logic [W-1:0] usub_res,
    output logic         usub_ovf,
    output logic [W-1:0] wrap_sum
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_ext;
    logic [W:0]   dif_ext;
    logic [W-1:0] rail;

    always_comb begin
        sum_ext  = {1'b0, a} + {1'b0, b};
        dif_ext  = {1'b0, a} - {1'b0, b};
        wrap_sum = sum_ext[W-1:0];
        // Clamp target follows the sign of the first operand.
        rail     = a[W-1] ? NEG_MIN : POS_MAX;

        sadd_ovf = ~(a[W-1] ^ b[W-1]) & (sum_ext[W-1] ^ a[W-1]);
        ssub_ovf =  (a[W-1] ^ b[W-1]) & (dif_ext[W-1] ^ a[W-1]);
        sadd_res = sadd_ovf ? rail : sum_ext[W-1:0];
        ssub_res = ssub_ovf ? rail : dif_ext[W-1:0];

        uadd_ovf = sum_ext[W];
        usub_ovf = dif_ext[W];
        uadd_res = uadd_ovf ? {W{1'b1}} : sum_ext[W-1:0];
        usub_res = usub_ovf ? {W{1'b0}} : dif_ext[W-1:0];
    end

endmodule

// File: rtl/sat_clamp.sv
// Saturates a signed value to n bits, as a signed or an unsigned range.
module sat_clamp #(
    parameter int unsigned W   = 32,
    localparam int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] width_n,
    input  logic           uns,
    output logic [W-1:0]   res,
    output logic           hit
);
    logic signed [W-1:0] sval;
    logic signed [W-1:0] top;
    logic [W-1:0]        mask;
    logic                above;
    logic                below;

    always_comb begin
        sval  = $signed(val);
        top   = sval >>> width_n;
        mask  = (W'(1) << width_n) - W'(1);
        res   = val;
        hit   = 1'b0;
        above = 1'b0;
        below = 1'b0;
        if (uns) begin
            below = val[W-1];
            above = !val[W-1] && (val > mask);
            if (below) begin
                res = '0;
            end else if (above) begin
                res = mask;
            end
        end else begin
            above = top > 0;
            below = top < -1;
            if (above) begin
                res = mask;
            end else if (below) begin
                res = ~mask;
            end
        end
        hit = above | below;
    end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SHW   = $clog2(DATA_W),
    localparam int unsigned HALF  = DATA_W / LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SHW-1:0]    sat_width,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] result,
    output logic              sat_flag
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              flag;
    } alu_state_t;

    alu_state_t state_d;
    alu_state_t state_q;
    sat_op_e    op_e;

    logic [DATA_W-1:0] sadd_res, ssub_res, uadd_res, usub_res, wrap_sum;
    logic              sadd_ovf, ssub_ovf, uadd_ovf, usub_ovf;
    logic [DATA_W-1:0] word_res;
    logic              word_hit;
    logic [DATA_W-1:0] lane_res [LANES];
    logic [LANES-1:0]  lane_hit;
    logic [DATA_W-1:0] lane_pack;
    logic              event_hit;

    assign op_e = sat_op_e'(op_code);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .sadd_res (sadd_res),
        .sadd_ovf (sadd_ovf),
        .ssub_res (ssub_res),
        .ssub_ovf (ssub_ovf),
        .uadd_res (uadd_res),
        .uadd_ovf (uadd_ovf),
        .usub_res (usub_res),
        .usub_ovf (usub_ovf),
        .wrap_sum (wrap_sum)
    );

    sat_clamp #(.W(DATA_W)) u_word (
        .val     (opnd_a),
        .width_n (sat_width),
        .uns     (op_e == SOP_USATW),
        .res     (word_res),
        .hit     (word_hit)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [HALF-1:0]   lane_in;
        logic [DATA_W-1:0] lane_ext;
        assign lane_in  = opnd_a[l*HALF +: HALF];
        assign lane_ext = {{(DATA_W-HALF){lane_in[HALF-1]}}, lane_in};

        sat_clamp #(.W(DATA_W)) u_lane (
            .val     (lane_ext),
            .width_n (sat_width),
            .uns     (op_e == SOP_USATH),
            .res     (lane_res[l]),
            .hit     (lane_hit[l])
        );

        assign lane_pack[l*HALF +: HALF] = lane_res[l][HALF-1:0];
    end

    always_comb begin
        state_d   = state_q;
        event_hit = 1'b0;
        case (op_e)
            SOP_SADD: begin
                state_d.result = sadd_res;
                event_hit      = sadd_ovf;
            end
            SOP_SSUB: begin
                state_d.result = ssub_res;
                event_hit      = ssub_ovf;
            end
            SOP_UADD: begin
                state_d.result = uadd_res;
                event_hit      = uadd_ovf;
            end
            SOP_USUB: begin
                state_d.result = usub_res;
                event_hit      = usub_ovf;
            end
            SOP_ADDF: begin
                state_d.result = wrap_sum;
                event_hit      = sadd_ovf;
            end
            SOP_SSATW, SOP_USATW: begin
                state_d.result = word_res;
                event_hit      = word_hit;
            end
            SOP_SSATH, SOP_USATH: begin
                state_d.result = lane_pack;
                event_hit      = |lane_hit;
            end
            default: begin
                state_d.result = state_q.result;
            end
        endcase
        // Clear first, then any event of this cycle sets the flag again.
        state_d.flag = (state_q.flag & ~flag_clr) | event_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result   = state_q.result;
    assign sat_flag = state_q.flag;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_code,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        flag_clr,
    input logic [31:0] result,
    input logic        sat_flag
);
    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAN: assert (result == '0 && !sat_flag); // R1
        end
    end

    AST_UADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd3 |=> result >= $past(opnd_a)); // R4

    AST_USUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd4 |=> result <= $past(opnd_a)); // R5

    AST_ADDF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd5 |=> result == $past(opnd_a) + $past(opnd_b)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag && !flag_clr |=> sat_flag); // R10

    AST_CLEAR_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && op_code == 4'd0 |=> !sat_flag); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd0 || op_code > 4'd9 |=> $stable(result)); // R12

    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 || op_code > 4'd9) && !sat_flag |=> !sat_flag); // R12

endmodule

bind sat_alu sat_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .flag_clr (flag_clr),
    .result   (result),
    .sat_flag (sat_flag)
);

// File: tb/sat_alu_bench.sv
`timescale 1ns/1ps
module sat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  sat_width = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_res = '0;
    logic        exp_flag = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sat_alu u_sat_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .sat_width (sat_width),
        .flag_clr  (flag_clr),
        .result    (result),
        .sat_flag  (sat_flag)
    );

    function automatic logic [32:0] m_sat(longint v, int n, bit uns);
        longint hi = (longint'(1) << n) - 1;
        longint lo = -(longint'(1) << n);
        if (uns) begin
            if (v < 0)  return {1'b1, 32'd0};
            if (v > hi) return {1'b1, hi[31:0]};
        end else begin
            if (v > hi) return {1'b1, hi[31:0]};
            if (v < lo) return {1'b1, lo[31:0]};
        end
        return {1'b0, v[31:0]};
    endfunction

    function automatic logic [32:0] m_op(logic [3:0] op, logic [31:0] a,
                                         logic [31:0] b, int n, logic [31:0] prev);
        longint s;
        logic [32:0] lo_l, hi_l;
        case (op)
            4'd1: return m_sat(longint'($signed(a)) + longint'($signed(b)), 31, 1'b0);
            4'd2: return m_sat(longint'($signed(a)) - longint'($signed(b)), 31, 1'b0);
            4'd3: begin
                s = longint'(a) + longint'(b);
                if (s > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
                return {1'b0, s[31:0]};
            end
            4'd4: begin
                if (b > a) return {1'b1, 32'd0};
                return {1'b0, a - b};
            end
            4'd5: begin
                lo_l = m_sat(longint'($signed(a)) + longint'($signed(b)), 31, 1'b0);
                return {lo_l[32], a + b};
            end
            4'd6: return m_sat(longint'($signed(a)), n, 1'b0);
            4'd7: return m_sat(longint'($signed(a)), n, 1'b1);
            4'd8, 4'd9: begin
                lo_l = m_sat(longint'($signed(a[15:0])), n, op == 4'd9);
                hi_l = m_sat(longint'($signed(a[31:16])), n, op == 4'd9);
                return {lo_l[32] | hi_l[32], hi_l[15:0], lo_l[15:0]};
            end
            default: return {1'b0, prev};
        endcase
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 6))
            0: return 32'h7FFF_FFFF - $urandom_range(0, 8);
            1: return 32'h8000_0000 + $urandom_range(0, 8);
            2: return 32'hFFFF_FFFF - $urandom_range(0, 8);
            3: return $urandom_range(0, 600);
            4: return {16'h7FFF - 16'($urandom_range(0, 300)), 16'($urandom_range(0, 300))};
            5: return {16'h8000 + 16'($urandom_range(0, 300)), 16'hFFFF - 16'($urandom_range(0, 300))};
            default: return $urandom;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic [4:0] n, logic clr);
        logic [32:0] m;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; sat_width = n; flag_clr = clr;
        m = m_op(op, a, b, int'(n), exp_res);
        exp_res  = m[31:0];
        exp_flag = (exp_flag & ~clr) | m[32];
        @(posedge clk);
        #1;
        check(req_of(op), "result", result, exp_res);
        check(clr ? "R11" : "R10", "flag", {31'd0, sat_flag}, {31'd0, exp_flag});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset result", result, 32'd0);
        check("R1", "reset flag", {31'd0, sat_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 signed add both rails, then clear on idle (R11, R12)
        apply(4'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b0);
        apply(4'd0, 32'h1234_5678, 32'h1, 5'd0, 1'b1);
        apply(4'd1, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 1'b0);
        apply(4'd1, 32'h0000_0005, 32'hFFFF_FFFD, 5'd0, 1'b0);
        // R3 signed subtract
        apply(4'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, 1'b1);
        apply(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0);
        // R4 / R5 unsigned
        apply(4'd3, 32'hFFFF_FFF0, 32'h0000_0020, 5'd0, 1'b1);
        apply(4'd4, 32'h0000_0005, 32'h0000_0006, 5'd0, 1'b1);
        apply(4'd4, 32'h0000_0006, 32'h0000_0006, 5'd0, 1'b1);
        // R6 flag-only add
        apply(4'd5, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 1'b0);
        // R10 non-saturating op keeps flag
        apply(4'd3, 32'h0000_0001, 32'h0000_0002, 5'd0, 1'b0);
        // R7 / R8 word saturate, R13 opnd_b irrelevant
        apply(4'd6, 32'd200, 32'hDEAD_BEEF, 5'd7, 1'b1);
        apply(4'd6, 32'hFFFF_FED4, 32'h0, 5'd7, 1'b1);
        apply(4'd6, 32'h0000_007F, 32'hFFFF_FFFF, 5'd7, 1'b1);
        apply(4'd7, 32'hFFFF_FFFB, 32'h5, 5'd8, 1'b1);
        apply(4'd7, 32'd300, 32'h5, 5'd8, 1'b1);
        apply(4'd7, 32'hFFFF_FFFF, 32'h5, 5'd31, 1'b1);
        // R9 dual-halfword, one lane and both lanes
        apply(4'd8, 32'h7FFF_8000, 32'h0, 5'd7, 1'b1);
        apply(4'd8, 32'h0005_8000, 32'h0, 5'd7, 1'b1);
        apply(4'd9, 32'h8000_0100, 32'h0, 5'd8, 1'b1);
        apply(4'd9, 32'h0010_0020, 32'h0, 5'd8, 1'b1);
        // R11 clear coinciding with a saturating event
        apply(4'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1'b1);
        // R12 undefined opcode holds result and does not set flag
        apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        apply(4'd13, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1'b0);

        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            op = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15))
                                             : 4'($urandom_range(0, 9));
            apply(op, pick_val(), pick_val(), 5'($urandom_range(0, 31)),
                  $urandom_range(0, 5) == 0);
        end

        done = 1'b1;
        summary();
    end

endmodule